// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Time

This block is a 16-bit up-counting timer that drives a pair of complementary PWM outputs. It is meant for half-bridge style loads, where the high-side and low-side switches must never conduct at the same time.

The counter runs from 1 up to a reload value, then starts again at 1 and emits a one-cycle reload pulse. Two events drive the outputs: a compare match and a reload. A polarity bit chooses which of the two events raises each output and which event lowers it. Each rising transition can be held back by a programmable number of clock cycles, the dead-time. Falling transitions take effect at once.

While the timer is disabled or in reset, the outputs rest at levels chosen by the polarity bit.

Top module: `cpwm_deadtime`

## Requirements
- R1: While `en` is low or `rst` is high, on the next clock edge `out_p` equals `pol`, `out_n` equals the inverse of `pol`, and `reload_pulse` is low.
- R2: With `en` high and a reload value R of 2 or more, `reload_pulse` is high for exactly one cycle in every R cycles. The first pulse appears R cycles after the first enabled clock edge.
- R3: With `pol` = 0, a compare match drives `out_p` high and `out_n` low, and a reload drives `out_p` low and `out_n` high.
- R4: With `pol` = 1, a compare match drives `out_p` low and `out_n` high, and a reload drives `out_p` high and `out_n` low.
- R5: With a dead-time of d > 0, an output that an event sets rises d clock cycles later than it would with a dead-time of 0. In steady state, with compare value C < R and d below the phase length, one output is high for R-C-d cycles of each period and the other is high for C-d cycles.
- R6: A falling transition is never delayed. An opposing event that arrives while a rise is pending cancels that rise, so the output stays low.
- R7: `out_p` and `out_n` are never high in the same cycle.
- R8: A compare value above the reload value, or equal to 0, never matches. With such a value, only reloads act on the outputs.
- R9: A dead-time of 0 raises the output on the same clock edge as the event that sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Timer enable |
| reload_val | input | 16 | Last count value of each period |
| cmp_val | input | 16 | Compare value for the match event |
| pol | input | 1 | Output polarity select |
| dead_cnt | input | 8 | Dead-time in clock cycles |
| out_p | output | 1 | Primary PWM output |
| out_n | output | 1 | Complement PWM output |
| reload_pulse | output | 1 | One-cycle pulse on each reload |

## Verification
Counter value v is evaluated on the v-th enabled clock edge. A match or reload therefore shows up on the registered outputs directly after that edge, and a delayed rise shows up d edges later. The bench counts samples taken at the falling clock edge from the first enabled edge. It expects the first reload pulse at sample R and a compare-driven change at sample C, with a dead-time rise moved to sample C+d. Duty-cycle and overlap counts are taken over a full period that starts at the second reload pulse, so the startup transient is excluded. Disable and reset effects are checked one sample after the edge that registers them.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  // set/clear request pair for one output leg
  typedef struct packed {
    logic set;
    logic clr;
  } leg_evt_t;

  localparam int unsigned LEG_P = 0;
  localparam int unsigned LEG_N = 1;
  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             rld_evt,
  output logic             mat_evt,
  output logic             reload_pulse
);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  // reload has priority; a match on the reload count is swallowed
  always_comb begin
    rld_evt = en && (cnt >= reload_val);
    mat_evt = en && !rld_evt && (cnt == cmp_val);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt          <= CNT_START;
      reload_pulse <= 1'b0;
    end else begin
      cnt          <= rld_evt ? CNT_START : cnt + CNT_W'(1);
      reload_pulse <= rld_evt;
    end
  end
endmodule

// File: rtl/cpwm_evt_route.sv
module cpwm_evt_route
  import cpwm_pkg::*;
(
  input  logic     pol,
  input  logic     rld_evt,
  input  logic     mat_evt,
  output leg_evt_t leg_evt  [NUM_LEGS],
  output logic     idle_lvl [NUM_LEGS]
);
  // leg index xor polarity picks which event raises the leg
  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    localparam logic INV = (g == LEG_N);
    logic swap;
    assign swap            = pol ^ INV;
    assign leg_evt[g].set  = swap ? rld_evt : mat_evt;
    assign leg_evt[g].clr  = swap ? mat_evt : rld_evt;
    assign idle_lvl[g]     = swap;
  end
endmodule

// File: rtl/cpwm_dt_leg.sv
module cpwm_dt_leg
  import cpwm_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            idle_lvl,
  input  leg_evt_t        evt,
  input  logic [DT_W-1:0] dead,
  output logic            out
);
  logic            pend;
  logic [DT_W-1:0] dly;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      out  <= idle_lvl;
      pend <= 1'b0;
      dly  <= '0;
    end else if (evt.clr) begin
      // falls are immediate and cancel a pending rise
      out  <= 1'b0;
      pend <= 1'b0;
    end else if (evt.set && dead == '0) begin
      out  <= 1'b1;
      pend <= 1'b0;
    end else if (evt.set && !out && !pend) begin
      pend <= 1'b1;
      dly  <= dead - DT_W'(1);
    end else if (pend) begin
      if (dly == '0) begin
        out  <= 1'b1;
        pend <= 1'b0;
      end else begin
        dly <= dly - DT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             pol,
  input  logic [DT_W-1:0]  dead_cnt,
  output logic             out_p,
  output logic             out_n,
  output logic             reload_pulse
);
  logic     rld_evt;
  logic     mat_evt;
  leg_evt_t leg_evt  [NUM_LEGS];
  logic     idle_lvl [NUM_LEGS];
  logic     leg_out  [NUM_LEGS];

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .reload_val   (reload_val),
    .cmp_val      (cmp_val),
    .rld_evt      (rld_evt),
    .mat_evt      (mat_evt),
    .reload_pulse (reload_pulse)
  );

  cpwm_evt_route u_route (
    .pol      (pol),
    .rld_evt  (rld_evt),
    .mat_evt  (mat_evt),
    .leg_evt  (leg_evt),
    .idle_lvl (idle_lvl)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    cpwm_dt_leg #(.DT_W(DT_W)) u_leg (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .idle_lvl (idle_lvl[g]),
      .evt      (leg_evt[g]),
      .dead     (dead_cnt),
      .out      (leg_out[g])
    );
  end

  assign out_p = leg_out[LEG_P];
  assign out_n = leg_out[LEG_N];
endmodule

// File: rtl/cpwm_deadtime_chk.sv
module cpwm_deadtime_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [CNT_W-1:0] reload_val,
  input logic             pol,
  input logic [DT_W-1:0]  dead_cnt,
  input logic             out_p,
  input logic             out_n,
  input logic             reload_pulse
);
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(out_p && out_n));

  a_r1_idle_levels: assert property (@(posedge clk) disable iff (rst)
    !en |=> (out_p == $past(pol)) && (out_n == !$past(pol)) && !reload_pulse);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (reload_pulse && reload_val > CNT_W'(1)) |=> !reload_pulse);

  // R6: the leg cleared by a reload drops on that very edge
  a_r6_fall_now: assert property (@(posedge clk) disable iff (rst)
    reload_pulse |-> ($past(pol) ? !out_n : !out_p));

  // R9: with no dead-time the leg set by a reload is high at once
  a_r9_rise_now: assert property (@(posedge clk) disable iff (rst)
    (reload_pulse && $past(dead_cnt) == '0) |-> ($past(pol) ? out_p : out_n));
endmodule

bind cpwm_deadtime cpwm_deadtime_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .en           (en),
  .reload_val   (reload_val),
  .pol          (pol),
  .dead_cnt     (dead_cnt),
  .out_p        (out_p),
  .out_n        (out_n),
  .reload_pulse (reload_pulse)
);

// File: tb/cpwm_deadtime_bench.sv
module cpwm_deadtime_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  localparam int MAXS  = 64;

  typedef struct packed {
    logic        pol;
    logic [15:0] rld;
    logic [15:0] cmp;
    logic [7:0]  dt;
    logic [7:0]  hi_p;
    logic [7:0]  hi_n;
  } vec_t;

  // expected high cycles per period for out_p / out_n
  localparam vec_t TBL [NV] = '{
    '{1'b0, 16'd10, 16'd4,  8'd0, 8'd6, 8'd4},
    '{1'b0, 16'd10, 16'd4,  8'd2, 8'd4, 8'd2},
    '{1'b1, 16'd10, 16'd4,  8'd2, 8'd2, 8'd4},
    '{1'b1, 16'd12, 16'd3,  8'd0, 8'd3, 8'd9},
    '{1'b0, 16'd8,  16'd20, 8'd1, 8'd0, 8'd8},
    '{1'b1, 16'd8,  16'd20, 8'd3, 8'd8, 8'd0},
    '{1'b0, 16'd10, 16'd3,  8'd3, 8'd4, 8'd0},
    '{1'b1, 16'd16, 16'd5,  8'd4, 8'd1, 8'd7}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] reload_val = 16'd10;
  logic [15:0] cmp_val    = 16'd4;
  logic        pol        = 1'b0;
  logic [7:0]  dead_cnt   = 8'd0;
  logic        out_p, out_n, reload_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic s_p [MAXS];
  logic s_n [MAXS];
  logic s_r [MAXS];

  always #(CLK_P/2) clk = ~clk;

  cpwm_deadtime u_cpwm_deadtime (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .reload_val   (reload_val),
    .cmp_val      (cmp_val),
    .pol          (pol),
    .dead_cnt     (dead_cnt),
    .out_p        (out_p),
    .out_n        (out_n),
    .reload_pulse (reload_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reset, configure, enable; sample i taken after the i-th enabled edge
  task automatic run(input logic p, input int r, input int c, input int d, input int n);
    @(negedge clk);
    rst = 1'b1; en = 1'b0; pol = p;
    reload_val = 16'(r); cmp_val = 16'(c); dead_cnt = 8'(d);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    en = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      s_p[i] = out_p; s_n[i] = out_n; s_r[i] = reload_pulse;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset levels, polarity 0
    repeat (2) @(negedge clk);
    chk(out_p == 1'b0, "R1 reset out_p", int'(out_p), 0);
    chk(out_n == 1'b1, "R1 reset out_n", int'(out_n), 1);
    chk(reload_pulse == 1'b0, "R1 reset pulse", int'(reload_pulse), 0);
    rst = 1'b0; pol = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_p == 1'b1, "R1 disabled pol1 out_p", int'(out_p), 1);
    chk(out_n == 1'b0, "R1 disabled pol1 out_n", int'(out_n), 0);

    // table walk: period, duty, overlap (R2 R3 R4 R5 R6 R7 R8)
    for (int v = 0; v < NV; v++) begin
      int r, np, nn, ov, npl;
      r = int'(TBL[v].rld);
      run(TBL[v].pol, r, int'(TBL[v].cmp), int'(TBL[v].dt), 3*r);
      npl = 0; np = 0; nn = 0; ov = 0;
      for (int i = 1; i <= 3*r; i++) begin
        npl += int'(s_r[i]);
        if (s_p[i] && s_n[i]) ov++;
      end
      for (int i = 2*r; i < 3*r; i++) begin
        np += int'(s_p[i]);
        nn += int'(s_n[i]);
      end
      chk(s_r[r] && s_r[2*r] && s_r[3*r] && npl == 3, "R2 pulse spacing", npl, 3);
      chk(np == int'(TBL[v].hi_p), TBL[v].pol ? "R4 R5 R8 out_p duty" : "R3 R5 R8 out_p duty",
          np, int'(TBL[v].hi_p));
      chk(nn == int'(TBL[v].hi_n), TBL[v].pol ? "R4 R6 out_n duty" : "R3 R6 out_n duty",
          nn, int'(TBL[v].hi_n));
      chk(ov == 0, "R7 overlap count", ov, 0);
    end

    // R9 / R3: no dead-time, match at sample C raises out_p immediately
    run(1'b0, 10, 4, 0, 12);
    chk(s_p[3] == 1'b0, "R3 out_p before match", int'(s_p[3]), 0);
    chk(s_p[4] == 1'b1, "R9 out_p at match", int'(s_p[4]), 1);
    chk(s_n[4] == 1'b0, "R3 out_n at match", int'(s_n[4]), 0);
    chk(s_p[10] == 1'b0 && s_n[10] == 1'b1, "R3 reload edge", int'(s_p[10]), 0);

    // R5 / R6 / R4: pol 1, dead 3, match at sample 4
    run(1'b1, 10, 4, 3, 12);
    chk(s_p[4] == 1'b0, "R6 out_p falls at match", int'(s_p[4]), 0);
    chk(s_n[6] == 1'b0, "R5 out_n held during dead-time", int'(s_n[6]), 0);
    chk(s_n[7] == 1'b1, "R5 out_n rises after dead-time", int'(s_n[7]), 1);
    chk(s_n[10] == 1'b0, "R4 out_n falls at reload", int'(s_n[10]), 0);

    // R1: disable mid-run returns idle levels on the next edge
    run(1'b0, 10, 4, 0, 6);
    en = 1'b0;
    @(negedge clk);
    chk(out_p == 1'b0 && out_n == 1'b1, "R1 disable out_p/out_n", int'({out_p, out_n}), 1);
    chk(reload_pulse == 1'b0, "R1 disable pulse", int'(reload_pulse), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule